// File: doc/BRIEF.md
# Ring-Oscillator Edge-Count Voltage Digitizer

This block turns a sampled voltage into a digital code by measuring how fast a voltage-controlled ring oscillator runs. The ring's tap outputs arrive asynchronously to the system clock. A single binary counter, clocked by the first tap, counts oscillator periods in the oscillator's own domain. On the system side, a window of a programmed number of reference-clock cycles is opened by a start pulse. The ring's phase state is captured at both ends of the window. The coarse period count and the two phase captures are combined into one code that counts individual ring stage transitions. Each transition is one stage delay of the ring rather than one full period.

The counter only needs enough throughput to follow every oscillator edge. Its value reaches the system clock as a Gray code through a two-flop synchronizer, and the ring taps pass through the same two-flop depth. Both ends of the window are therefore seen at the same delay. The code is the average oscillator rate over the window, so a longer window gives a finer step. The phase at the start of the window is arbitrary, which adds up to one step of dither that downstream averaging can exploit. A one-cycle done strobe marks a new result.

Top module: `vco_count_adc`

## Requirements
- R1: While reset is held and after its release until the first conversion ends, `done` is 0 and `code` is 0.
- R2: Each tap word is decoded as a ring phase. For phase p in 0..2N-1, tap k is 1 exactly when k < p <= k+N, where N is the number of taps. The result `code` equals the number of ring phase steps between the two window edges. It is formed as 2N times the coarse count plus the end phase minus the start phase.
- R3: The code scales with oscillator rate and window length. With a stage delay of S ns and a 125 MHz clock, a window of L cycles gives 8L/S whenever that is a whole number.
- R4: A start pulse that arrives while a conversion is running has no effect on that conversion's result or its end time.
- R5: A start sampled at clock edge E0 with length L produces `done` high for exactly one cycle, starting at edge E0+L+1.
- R6: A programmed length of 0 is treated as a window of one cycle.
- R7: The coarse count saturates instead of wrapping. If it would exceed 2^COARSE_W-1, `code` is all ones. A count of exactly 2^COARSE_W-1 is still reported exactly.
- R8: A start sampled at the same edge that raises `done` begins a new conversion, and the finished result is still delivered intact.
- R9: `code` changes only at the edge that raises `done` and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System/reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ring_taps | input | NTAP | Ring oscillator stage outputs, asynchronous |
| start | input | 1 | Request to open a conversion window |
| win_len | input | WIN_W | Window length in reference-clock cycles |
| code | output | COARSE_W+log2(2*NTAP) | Combined coarse and fine conversion code |
| done | output | 1 | One-cycle strobe, new code available |

## Verification
Two events can land on the same clock edge. One is the edge where a finished conversion raises `done`. The other is the edge where a new start is accepted. The bench raises `start` in the cycle just before `done` rises, with a different window length. It then checks that the first result and its timing are unchanged, and that the second conversion ends after its own length with its own code. A start raised in the middle of a running window is judged the same way: the running conversion's length and code must stay untouched.

// File: rtl/vco_count_adc.sv
`timescale 1ns/1ps
module vco_count_adc #(
  parameter  int NTAP     = 4,
  parameter  int COARSE_W = 20,
  parameter  int WIN_W    = 16,
  localparam int PH_W     = $clog2(2*NTAP),
  localparam int CODE_W   = COARSE_W + PH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTAP-1:0]   ring_taps,
  input  logic              start,
  input  logic [WIN_W-1:0]  win_len,
  output logic [CODE_W-1:0] code,
  output logic              done
);

  function automatic logic [PH_W:0] ph_dec(input logic [NTAP-1:0] t);
    logic [PH_W:0] ones;
    ones = '0;
    for (int k = 0; k < NTAP; k++) ones = ones + {{PH_W{1'b0}}, t[k]};
    if (t[NTAP-1])      ph_dec = (PH_W+1)'(2*NTAP) - ones;
    else if (ones == 0) ph_dec = (PH_W+1)'(2*NTAP);
    else                ph_dec = ones;
  endfunction

  function automatic logic [COARSE_W-1:0] g2b(input logic [COARSE_W-1:0] g);
    logic [COARSE_W-1:0] b;
    b[COARSE_W-1] = g[COARSE_W-1];
    for (int i = COARSE_W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // oscillator domain: free-running counter published as Gray code
  logic [COARSE_W-1:0] ocnt, ogray;
  wire  [COARSE_W-1:0] onext = ocnt + 1'b1;

  always_ff @(posedge ring_taps[0] or negedge rst_n)
    if (!rst_n) begin
      ocnt  <= '0;
      ogray <= '0;
    end else begin
      ocnt  <= onext;
      ogray <= onext ^ (onext >> 1);
    end

  // reference domain
  logic [NTAP-1:0]     tap_m, tap_s;
  logic [COARSE_W-1:0] gry_m, gry_s, cnt_prev, acc, coarse_r;
  logic [WIN_W-1:0]    rem;
  logic [PH_W:0]       s_idx, e_idx;
  logic                busy, ovf, ovf_r, fin;

  wire [COARSE_W-1:0] cnt_now  = g2b(gry_s);
  wire [COARSE_W:0]   acc_sum  = {1'b0, acc} + {1'b0, cnt_now - cnt_prev};
  wire                ovf_nxt  = ovf | acc_sum[COARSE_W];
  wire [COARSE_W-1:0] acc_nxt  = acc_sum[COARSE_W] ? '1 : acc_sum[COARSE_W-1:0];
  wire [CODE_W-1:0]   code_asm = ovf_r ? '1 :
                                 ({coarse_r, {PH_W{1'b0}}} + CODE_W'(e_idx) - CODE_W'(s_idx));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tap_m <= '0; tap_s <= '0; gry_m <= '0; gry_s <= '0;
      cnt_prev <= '0; acc <= '0; coarse_r <= '0; rem <= '0;
      s_idx <= '0; e_idx <= '0; busy <= 1'b0; ovf <= 1'b0; ovf_r <= 1'b0;
      fin <= 1'b0; done <= 1'b0; code <= '0;
    end else begin
      tap_m <= ring_taps; tap_s <= tap_m;
      gry_m <= ogray;     gry_s <= gry_m;
      done  <= fin;
      fin   <= 1'b0;
      if (fin) code <= code_asm;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          rem      <= (win_len == '0) ? WIN_W'(1) : win_len;
          s_idx    <= ph_dec(tap_s);
          cnt_prev <= cnt_now;
          acc      <= '0;
          ovf      <= 1'b0;
        end
      end else begin
        cnt_prev <= cnt_now;
        acc      <= acc_nxt;
        ovf      <= ovf_nxt;
        rem      <= rem - 1'b1;
        if (rem == WIN_W'(1)) begin
          busy     <= 1'b0;
          coarse_r <= acc_nxt;
          ovf_r    <= ovf_nxt;
          e_idx    <= ph_dec(tap_s);
          fin      <= 1'b1;
        end
      end
    end

endmodule

module vco_count_adc_chk #(
  parameter int NTAP = 4, parameter int COARSE_W = 20, parameter int WIN_W = 16,
  parameter int PH_W = 3, parameter int CODE_W = 23
) (
  input logic                clk,
  input logic                rst_n,
  input logic                done,
  input logic [CODE_W-1:0]   code,
  input logic                busy,
  input logic [WIN_W-1:0]    rem,
  input logic [COARSE_W-1:0] acc,
  input logic [PH_W:0]       s_idx
);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_follow_r5: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |=> done);
  p_window_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rem != WIN_W'(1)) |=> (busy && rem == $past(rem) - 1'b1));
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (acc >= $past(acc)));
  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(code));
  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (s_idx >= (PH_W+1)'(1) && s_idx <= (PH_W+1)'(2*NTAP)));
endmodule

bind vco_count_adc vco_count_adc_chk #(
  .NTAP(NTAP), .COARSE_W(COARSE_W), .WIN_W(WIN_W), .PH_W(PH_W), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .code(code),
  .busy(busy), .rem(rem), .acc(acc), .s_idx(s_idx)
);

// File: tb/test_vco_count_adc.sv
`timescale 1ns/1ps
module test_vco_count_adc;
  localparam int NT = 4, CW = 10, WW = 16, CDW = CW + 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [WW-1:0] win_len = '0;
  logic [NT-1:0] taps = '0;
  wire  [CDW-1:0] code;
  wire  done;
  int n_chk = 0, n_bad = 0, cyc = 0, stg_ns = 8, ph = 0;

  vco_count_adc #(.NTAP(NT), .COARSE_W(CW), .WIN_W(WW)) i_vco_count_adc (
    .clk(clk), .rst_n(rst_n), .ring_taps(taps), .start(start),
    .win_len(win_len), .code(code), .done(done));

  always #4 clk = ~clk;

  // ring model: phase steps at x.5 ns, never on a clock edge
  initial begin
    #0.5;
    forever begin
      ph = (ph + 1) % (2*NT);
      for (int k = 0; k < NT; k++) taps[k] = (ph > k) && (ph <= k + NT);
      #(stg_ns);
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // lat counts negedges after the start-sampling edge (0 = right after it)
  task automatic conv(input int L, input int inj_at, input int inj_len,
                      output int lat, output int cval);
    @(negedge clk); start = 1'b1; win_len = WW'(L);
    @(negedge clk); start = (inj_at == 0); lat = 0;
    while (!done && lat < 5000) begin
      @(negedge clk); lat++;
      start = (lat == inj_at);
      if (lat == inj_at) win_len = WW'(inj_len);
    end
    start = 1'b0;
    cval = int'(code);
  endtask

  task automatic wait_done(output int lat, output int cval);
    lat = 0;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
    cval = int'(code);
  endtask

  task automatic set_rate(input int s);
    stg_ns = s;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    #20;
    check(done == 1'b0 && code == '0, "R1 in reset", int'(code), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(done == 1'b0 && code == '0, "R1 after release", int'(code), 0);
  endtask

  task automatic t_basic();
    int lat, c;
    set_rate(8);
    conv(100, -1, 0, lat, c); check(c == 100, "R2 S=8 L=100", c, 100);
    check(lat == 101, "R5 latency L=100", lat, 101);
    conv(37, -1, 0, lat, c);  check(c == 37, "R2 S=8 L=37", c, 37);
    set_rate(2);
    conv(37, -1, 0, lat, c);  check(c == 148, "R2 S=2 L=37", c, 148);
  endtask

  task automatic t_rate();
    int lat, c;
    set_rate(4);  conv(100, -1, 0, lat, c); check(c == 200, "R3 S=4 L=100", c, 200);
    set_rate(2);  conv(100, -1, 0, lat, c); check(c == 400, "R3 S=2 L=100", c, 400);
    set_rate(16); conv(100, -1, 0, lat, c); check(c == 50,  "R3 S=16 L=100", c, 50);
    set_rate(1);  conv(50, -1, 0, lat, c);  check(c == 400, "R3 S=1 L=50", c, 400);
    check(lat == 51, "R5 latency L=50", lat, 51);
  endtask

  task automatic t_ignore();
    int lat, c;
    set_rate(8);
    conv(60, 10, 5, lat, c);
    check(lat == 61, "R4 end time kept", lat, 61);
    check(c == 60, "R4 code kept", c, 60);
  endtask

  task automatic t_zero();
    int lat, c;
    set_rate(8);
    conv(0, -1, 0, lat, c);
    check(lat == 2, "R6 zero length latency", lat, 2);
    check(c == 1, "R6 zero length code", c, 1);
  endtask

  task automatic t_sat();
    int lat, c;
    set_rate(1);
    conv(1023, -1, 0, lat, c); check(c == 8184, "R7 at limit", c, 8184);
    conv(1024, -1, 0, lat, c); check(c == 8191, "R7 saturated", c, 8191);
    conv(1500, -1, 0, lat, c); check(c == 8191, "R7 well over", c, 8191);
  endtask

  task automatic t_b2b();
    int lat, c, lat2, c2;
    set_rate(4);
    conv(40, 40, 25, lat, c);
    check(lat == 41, "R8 first latency", lat, 41);
    check(c == 80, "R8 first code", c, 80);
    @(negedge clk);
    wait_done(lat2, c2);
    check(lat2 == 25, "R8 second latency", lat2 + 1, 26);
    check(c2 == 50, "R8 second code", c2, 50);
  endtask

  task automatic t_hold();
    int lat, c, pulses;
    set_rate(8);
    conv(30, -1, 0, lat, c);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) pulses++;
      if (code != CDW'(c)) pulses += 100;
    end
    check(pulses == 0, "R9 code held, no extra strobe", pulses, 0);
    check(c == 30, "R9 held value", int'(code), 30);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_rate();
    t_ignore();
    t_zero();
    t_sat();
    t_b2b();
    t_hold();
    summary();
    $finish;
  end
endmodule